// File: doc/BRIEF.md
# Scalar Index Arithmetic Unit

This unit keeps a small bank of sixteen scalar registers and runs one arithmetic instruction at a time on them. A sequencer uses it to compute loop indices, strides and addresses. Each instruction names a 3-bit operation, two 7-bit operands and a 4-bit destination register. Each operand has its own flag that says whether the field is a literal value or selects a register. The result is written back into the bank one cycle after the instruction is accepted.

The bank has a separate read port so that neighbouring units can fetch the current value of any register, for example to resolve a parameter held there. Two operations, multiply-add and multiply-subtract, also use the destination's previous value. Every operation reads the bank through a bypass of the pending write, so an instruction may depend on the result of the instruction issued in the cycle before it.

Top module: `sia_top`

## Requirements
- R1: After reset every register reads as zero on the read port and `wr_done` is low.
- R2: Mode 1 writes op1+op2 and mode 2 writes op1-op2, both as 16-bit two's complement values that wrap on overflow.
- R3: Mode 3 writes op1 shifted right, with zero fill, by op2[3:0] places. Mode 4 writes op1 shifted left by op2[3:0] places.
- R4: Mode 5 writes the low 16 bits of op1*op2.
- R5: Mode 6 writes the destination's previous value plus the low 16 bits of op1*op2. Mode 7 writes the previous value minus that product. Both wrap.
- R6: An operand whose flag is 0 is its 7-bit field zero-extended to 16 bits. An operand whose flag is 1 is the register selected by field[3:0]; field[6:4] is ignored.
- R7: Mode 0 (idle) leaves every register unchanged and raises no `wr_done`.
- R8: An instruction sampled with `instr_valid` high at clock edge k updates its destination at edge k+1. `wr_done` is high for exactly the cycle that follows edge k+1, and only for non-idle modes.
- R9: An instruction issued in the cycle right after another one sees that earlier result, both in its operands and in the destination's previous value.
- R10: After each clock edge, `rd_data` holds the register selected by `rd_addr` at that edge, and this includes a write made at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| mode | input | 3 | Operation code |
| op1_dyn | input | 1 | Operand 1 selects a register when high |
| op1_field | input | 7 | Operand 1 literal or register index |
| op2_dyn | input | 1 | Operand 2 selects a register when high |
| op2_field | input | 7 | Operand 2 literal or register index |
| dest | input | 4 | Destination register |
| rd_addr | input | 4 | Read port register index |
| rd_data | output | 16 | Registered read port data |
| wr_done | output | 1 | Pulses in the cycle after a write-back |

## Verification
Two things can fall in the same cycle: the write-back of one instruction, and the operand and previous-value reads of the next instruction, which may name the same register. The bench provokes this by issuing back-to-back instructions. In each pair the second one reads the first one's destination, both dynamically and as a multiply-add or multiply-subtract target, while the read port watches that register. The outcome is judged against a bench model of the register file that applies the first result before it evaluates the second.

// File: rtl/sia_pkg.sv
package sia_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SHR  = 3'd3,
    OP_SHL  = 3'd4,
    OP_MUL  = 3'd5,
    OP_MADD = 3'd6,
    OP_MSUB = 3'd7
  } sia_op_e;
endpackage

// File: rtl/sia_regbank.sv
module sia_regbank #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr [NRD],
  output logic [DW-1:0] rdata [NRD]
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  // each read sees the write that lands at the coming edge
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (we && waddr == raddr[p]) ? wdata : mem_q[raddr[p]];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> mem_q[$past(waddr)] == $past(wdata)); // R8
endmodule

// File: rtl/sia_operand.sv
module sia_operand #(
  parameter int DW  = 16,
  parameter int OPW = 7,
  parameter int AW  = 4
) (
  input  logic           dyn,
  input  logic [OPW-1:0] field,
  input  logic [DW-1:0]  regval,
  output logic [AW-1:0]  sel,
  output logic [DW-1:0]  value
);
  assign sel   = field[AW-1:0];
  assign value = dyn ? regval : {{(DW-OPW){1'b0}}, field};
endmodule

// File: rtl/sia_alu.sv
module sia_alu
  import sia_pkg::*;
#(
  parameter int DW  = 16,
  localparam int SHW = $clog2(DW)
) (
  input  sia_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] prev,
  output logic [DW-1:0] result,
  output logic          writes
);
  logic [DW-1:0] prod;
  assign prod = a * b;

  always_comb begin
    writes = 1'b1;
    unique case (op)
      OP_ADD:  result = a + b;
      OP_SUB:  result = a - b;
      OP_SHR:  result = a >> b[SHW-1:0];
      OP_SHL:  result = a << b[SHW-1:0];
      OP_MUL:  result = prod;
      OP_MADD: result = prev + prod;
      OP_MSUB: result = prev - prod;
      default: begin
        result = '0;
        writes = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sia_top.sv
module sia_top
  import sia_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 16,
  parameter int OPW  = 7,
  localparam int AW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           instr_valid,
  input  logic [2:0]     mode,
  input  logic           op1_dyn,
  input  logic [OPW-1:0] op1_field,
  input  logic           op2_dyn,
  input  logic [OPW-1:0] op2_field,
  input  logic [AW-1:0]  dest,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           wr_done
);
  localparam int NRD = 4; // op1, op2, previous destination, external

  logic [AW-1:0] raddr [NRD];
  logic [DW-1:0] rdata [NRD];
  logic [DW-1:0] a_val, b_val, alu_res;
  logic          alu_wr;

  logic          pend_q;
  logic [AW-1:0] pend_dst_q;
  logic [DW-1:0] pend_val_q;
  logic          done_q;
  logic [DW-1:0] rd_q;

  sia_regbank #(.DW(DW), .NREG(NREG), .NRD(NRD)) bank_i (
    .clk(clk), .rst(rst),
    .we(pend_q), .waddr(pend_dst_q), .wdata(pend_val_q),
    .raddr(raddr), .rdata(rdata)
  );

  sia_operand #(.DW(DW), .OPW(OPW), .AW(AW)) opa_i (
    .dyn(op1_dyn), .field(op1_field), .regval(rdata[0]),
    .sel(raddr[0]), .value(a_val)
  );

  sia_operand #(.DW(DW), .OPW(OPW), .AW(AW)) opb_i (
    .dyn(op2_dyn), .field(op2_field), .regval(rdata[1]),
    .sel(raddr[1]), .value(b_val)
  );

  assign raddr[2] = dest;
  assign raddr[3] = rd_addr;

  sia_alu #(.DW(DW)) alu_i (
    .op(sia_op_e'(mode)), .a(a_val), .b(b_val), .prev(rdata[2]),
    .result(alu_res), .writes(alu_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      pend_dst_q <= '0;
      pend_val_q <= '0;
      done_q     <= 1'b0;
      rd_q       <= '0;
    end else begin
      pend_q     <= instr_valid && alu_wr;
      pend_dst_q <= dest;
      pend_val_q <= alu_res;
      done_q     <= pend_q;
      rd_q       <= rdata[3];
    end
  end

  assign rd_data = rd_q;
  assign wr_done = done_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && mode == 3'd0 && !pend_q) |=> ##1 !wr_done); // R7
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && mode != 3'd0) |=> ##1 wr_done); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_done) |-> $past(pend_q)); // R8
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!instr_valid || mode == 3'd0) |=> !pend_q); // R7
endmodule

// File: tb/sia_top_tb_top.sv
module sia_top_tb_top;
  logic        clk = 0;
  logic        rst;
  logic        instr_valid;
  logic [2:0]  mode;
  logic        op1_dyn, op2_dyn;
  logic [6:0]  op1_field, op2_field;
  logic [3:0]  dest, rd_addr;
  logic [15:0] rd_data;
  logic        wr_done;

  int total = 0;
  int bad = 0;
  logic [15:0] model [16];

  always #5 clk = ~clk;

  sia_top dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .mode(mode),
    .op1_dyn(op1_dyn), .op1_field(op1_field),
    .op2_dyn(op2_dyn), .op2_field(op2_field),
    .dest(dest), .rd_addr(rd_addr), .rd_data(rd_data), .wr_done(wr_done)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] opval(logic d, logic [6:0] f);
    return d ? model[f[3:0]] : {9'd0, f};
  endfunction

  function automatic logic [15:0] calc(logic [2:0] m, logic [15:0] a,
                                       logic [15:0] b, logic [15:0] p);
    logic [15:0] pr;
    pr = a * b;
    case (m)
      3'd1: return a + b;
      3'd2: return a - b;
      3'd3: return a >> b[3:0];
      3'd4: return a << b[3:0];
      3'd5: return pr;
      3'd6: return p + pr;
      3'd7: return p - pr;
      default: return p;
    endcase
  endfunction

  function automatic logic [6:0] pick(int i);
    case (i)
      0: return 7'd0;   1: return 7'd1;  2: return 7'd2;   3: return 7'd5;
      4: return 7'd15;  5: return 7'd63; 6: return 7'd100; default: return 7'd127;
    endcase
  endfunction

  // drives an instruction and updates the model, returns expected result
  task automatic put(logic [2:0] m, logic d1, logic [6:0] f1, logic d2,
                     logic [6:0] f2, logic [3:0] dst, output logic [15:0] exp);
    exp = calc(m, opval(d1, f1), opval(d2, f2), model[dst]);
    if (m != 3'd0) model[dst] = exp;
    instr_valid = 1; mode = m; op1_dyn = d1; op1_field = f1;
    op2_dyn = d2; op2_field = f2; dest = dst;
  endtask

  task automatic single(string req, logic [2:0] m, logic d1, logic [6:0] f1,
                        logic d2, logic [6:0] f2, logic [3:0] dst);
    logic [15:0] e;
    put(m, d1, f1, d2, f2, dst, e);
    rd_addr = dst;
    @(posedge clk); @(negedge clk);
    instr_valid = 0;
    chk("R8 no done before write", {15'd0, wr_done}, 16'd0);
    @(posedge clk); @(negedge clk);
    chk(req, rd_data, model[dst]);
    chk((m == 3'd0) ? "R7 done" : "R8 done", {15'd0, wr_done}, {15'd0, m != 3'd0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] ea, eb, ec;
    for (int i = 0; i < 16; i++) model[i] = 16'd0;
    rst = 1; instr_valid = 0; mode = 0; op1_dyn = 0; op2_dyn = 0;
    op1_field = 0; op2_field = 0; dest = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state through the read port
    chk("R1 done low", {15'd0, wr_done}, 16'd0);
    for (int r = 0; r < 16; r++) begin
      rd_addr = r[3:0];
      @(posedge clk); @(negedge clk);
      chk("R1 reset zero", rd_data, 16'd0);
    end

    // R2 R3 R4 R5: immediate sweep over all writing modes
    for (int m = 1; m < 8; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          single((m < 3) ? "R2 add/sub" : (m < 5) ? "R3 shift" :
                 (m == 5) ? "R4 mul" : "R5 mul-acc",
                 m[2:0], 1'b0, pick(i), 1'b0, pick(j), 4'((i * 8 + j + m) % 16));

    // R6: load registers, then dynamic operands with junk in field[6:4]
    for (int k = 0; k < 16; k++)
      single("R6 load", 3'd1, 1'b0, 7'(k * 7 + 3), 1'b0, 7'(k * 5), k[3:0]);
    for (int i = 0; i < 16; i++)
      for (int m = 1; m < 8; m++)
        single("R6 dynamic operand", m[2:0], 1'b1, {3'(i + m), 4'(i)},
               (m % 2) == 1, {3'b101, 4'(15 - i)}, 4'((i + 3 * m) % 16));

    // R7: idle never writes
    for (int k = 0; k < 16; k++)
      single("R7 idle keeps value", 3'd0, 1'b0, 7'd99, 1'b0, 7'd3, k[3:0]);

    // R9 R10: back-to-back dependence on register 3
    put(3'd1, 1'b0, 7'd50, 1'b0, 7'd20, 4'd3, ea);
    rd_addr = 4'd3;
    @(posedge clk); @(negedge clk);
    put(3'd6, 1'b1, 7'd3, 1'b0, 7'd2, 4'd3, eb);       // 70 + 70*2
    @(posedge clk); @(negedge clk);
    chk("R10 read sees same-edge write", rd_data, ea);
    chk("R8 done first", {15'd0, wr_done}, 16'd1);
    put(3'd7, 1'b1, 7'd3, 1'b1, 7'd3, 4'd3, ec);       // 210 - 210*210
    @(posedge clk); @(negedge clk);
    instr_valid = 0;
    chk("R9 forward into madd", rd_data, eb);
    chk("R9 expected madd", eb, 16'd210);
    @(posedge clk); @(negedge clk);
    chk("R9 forward into msub", rd_data, ec);
    chk("R9 expected msub", ec, 16'(210 - 210 * 210));
    @(posedge clk); @(negedge clk);
    chk("R8 done ends", {15'd0, wr_done}, 16'd0);

    // R9: idle right after a write does not disturb it
    put(3'd4, 1'b0, 7'd1, 1'b0, 7'd15, 4'd9, ea);
    rd_addr = 4'd9;
    @(posedge clk); @(negedge clk);
    put(3'd0, 1'b1, 7'd9, 1'b0, 7'd1, 4'd9, eb);
    @(posedge clk); @(negedge clk);
    instr_valid = 0;
    chk("R3 shift into sign bit", rd_data, 16'h8000);
    @(posedge clk); @(negedge clk);
    chk("R7 idle after write", rd_data, 16'h8000);
    chk("R7 no done", {15'd0, wr_done}, 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule